// File: doc/BRIEF.md
# Serial Quad-Channel Setting Register Interface

This block sits between a three-wire serial host port (select, clock, data-in) and four 8-bit channel settings that drive downstream converters. A frame carries a start bit, a channel address and a new 8-bit value. While the new value arrives, the channel's present value is shifted back out on a data-out line, so every write is also a read. The data-out line has an output enable that follows the select input, so several devices can share one return wire.

Values written over the serial port are temporary. Each channel output shows its written value only while select stays high. When select goes low, or while the power-on reset is asserted, every channel shows the value on the non-volatile shadow input. No serial clock is needed for this. Each completed frame raises a one-cycle pulse that carries the address and the new value, for a separate programming controller that commits values to non-volatile storage.

Top module: `setting_shift_if`

## Requirements
- R1: With select high and no frame in progress, a 0 sampled on `di` is idle and starts nothing. A 1 sampled on a rising edge is the start bit of a frame.
- R2: The two address bits follow the start bit, low bit first. The address selects `ch_val[8*a +: 8]`, where a = {second bit, first bit}.
- R3: In the cycle after the second address bit is sampled, `dout` shows bit 0 of the addressed channel's present value, including any temporary value. After each of the next seven edges it shows the next higher bit. At all other times `dout` is 0.
- R4: The eight data bits arrive LSB first. On the edge that samples the last data bit, the addressed channel takes the new value. No other channel changes.
- R5: In the cycle after the last data bit, `done` is high for exactly one cycle, with `done_addr` and `done_data` equal to the address and value just written.
- R6: The two edges after the last data bit are ignored whatever `di` holds. A start bit on the third edge is accepted.
- R7: `dout_oe` is high exactly while `cs` is high.
- R8: While `cs` is low, `ch_val` equals `nv_data` without waiting for a clock edge. A clock edge with `cs` low discards all temporary values and any partly received frame.
- R9: While `rst_n` is low, `ch_val` equals `nv_data` with no clock edge needed. `done` and `dout_oe` (with `cs` low) are 0.
- R10: If `cs` drops before the last data bit, no channel is written and no `done` pulse appears. The channels keep showing their shadow values, so a read-only poll changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cs | input | 1 | Select; high enables transfers, low restores shadow values |
| di | input | 1 | Serial data in |
| nv_data | input | 32 | Non-volatile shadow values, channel a in bits [8a+7:8a] |
| dout | output | 1 | Serial data out, present value LSB first |
| dout_oe | output | 1 | Output enable for the shared data-out wire |
| ch_val | output | 32 | Effective channel settings, channel a in bits [8a+7:8a] |
| done | output | 1 | One-cycle frame-complete pulse |
| done_addr | output | 2 | Address of the completed frame |
| done_data | output | 8 | Value written by the completed frame |

## Verification
The assertions assume that `nv_data` holds still while select is high. The bench keeps it constant for the whole run. They also assume that `cs` and `di` change only between rising edges and that frames respect the two-edge gap. The bench drives every input on the falling edge and builds each frame through one task that always inserts the gap, except where a test deliberately aborts the frame by dropping select.

// File: rtl/setting_shift_if.sv
module setting_shift_if #(
  parameter int CH  = 4,
  parameter int W   = 8,
  parameter int GAP = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs,
  input  logic            di,
  input  logic [CH*W-1:0] nv_data,
  output logic            dout,
  output logic            dout_oe,
  output logic [CH*W-1:0] ch_val,
  output logic            done,
  output logic [$clog2(CH)-1:0] done_addr,
  output logic [W-1:0]    done_data
);
  localparam int AW = $clog2(CH);
  localparam int CW = $clog2(W + GAP) + 1;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_GAP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr;
  logic [AW-1:0] next_addr;
  logic [W-1:0]  sh;
  logic [W-1:0]  vol [CH];
  logic [W-1:0]  eff [CH];
  logic [CH-1:0] ovr;

  for (genvar i = 0; i < CH; i++) begin : g_ch
    assign eff[i] = (cs && ovr[i]) ? vol[i] : nv_data[i*W +: W];
    assign ch_val[i*W +: W] = eff[i];
  end

  assign next_addr = AW'({di, addr} >> 1);
  assign dout_oe   = cs;
  assign dout      = (st == S_DATA) ? sh[0] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      addr      <= '0;
      sh        <= '0;
      ovr       <= '0;
      done      <= 1'b0;
      done_addr <= '0;
      done_data <= '0;
      for (int i = 0; i < CH; i++) vol[i] <= '0;
    end else begin
      done <= 1'b0;
      if (!cs) begin
        st  <= S_IDLE;
        cnt <= '0;
        ovr <= '0;
      end else begin
        case (st)
          S_IDLE: if (di) begin
            st  <= S_ADDR;
            cnt <= '0;
          end
          S_ADDR: begin
            addr <= next_addr;
            if (cnt == CW'(AW - 1)) begin
              sh  <= eff[next_addr];
              st  <= S_DATA;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            sh <= {di, sh[W-1:1]};
            if (cnt == CW'(W - 1)) begin
              vol[addr]  <= {di, sh[W-1:1]};
              ovr[addr]  <= 1'b1;
              done       <= 1'b1;
              done_addr  <= addr;
              done_data  <= {di, sh[W-1:1]};
              st         <= S_GAP;
              cnt        <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: begin
            if (cnt == CW'(GAP - 1)) begin
              st  <= S_IDLE;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

module setting_shift_if_chk #(
  parameter int CH = 4,
  parameter int W  = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs,
  input logic [CH*W-1:0]       nv_data,
  input logic                  dout,
  input logic                  dout_oe,
  input logic [CH*W-1:0]       ch_val,
  input logic                  done,
  input logic [$clog2(CH)-1:0] done_addr,
  input logic [W-1:0]          done_data
);
  AST_DONE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cs)); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_COMMIT_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cs) |-> ch_val[done_addr*W +: W] == done_data); // R4
  AST_SHADOW_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> ch_val == nv_data); // R8
  AST_OE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs) |-> !dout_oe); // R7
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && $past(cs) && $stable(nv_data) && !done) |-> $stable(ch_val)); // R4
  AST_DOUT_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs && $past(!cs)) |-> !dout); // R3
endmodule

bind setting_shift_if setting_shift_if_chk #(.CH(CH), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .nv_data(nv_data), .dout(dout),
  .dout_oe(dout_oe), .ch_val(ch_val), .done(done), .done_addr(done_addr),
  .done_data(done_data)
);

// File: tb/setting_shift_if_test.sv
module setting_shift_if_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0;
  logic        di = 1'b0;
  logic [31:0] nv_data = 32'hC3_5A_81_17;
  logic        dout, dout_oe, done;
  logic [31:0] ch_val;
  logic [1:0]  done_addr;
  logic [7:0]  done_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  setting_shift_if uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .di(di), .nv_data(nv_data),
    .dout(dout), .dout_oe(dout_oe), .ch_val(ch_val), .done(done),
    .done_addr(done_addr), .done_data(done_data)
  );

  always #10 clk = ~clk;

  // reference model
  int         mpos = 0;
  logic [1:0] maddr = 0;
  logic [7:0] mcur = 0, mnew = 0;
  logic [7:0] mvol [4] = '{default: 0};
  bit         movr [4] = '{default: 0};
  bit         mdone = 0;
  logic [1:0] mdaddr = 0;
  logic [7:0] mddata = 0;

  function automatic logic [7:0] exp_ch(int i);
    return (cs && movr[i]) ? mvol[i] : nv_data[i*8 +: 8];
  endfunction

  function automatic logic [31:0] exp_all();
    logic [31:0] v;
    for (int i = 0; i < 4; i++) v[i*8 +: 8] = exp_ch(i);
    return v;
  endfunction

  task automatic model_step(input bit c, input bit d);
    mdone = 0;
    if (!c) begin
      mpos = 0;
      for (int i = 0; i < 4; i++) movr[i] = 0;
    end else if (mpos == 0) begin
      if (d) mpos = 1;
    end else if (mpos <= 2) begin
      maddr[mpos-1] = d;
      if (mpos == 2) mcur = exp_ch(maddr);
      mpos++;
    end else if (mpos <= 10) begin
      mnew[mpos-3] = d;
      if (mpos == 10) begin
        mvol[maddr] = mnew; movr[maddr] = 1;
        mdone = 1; mdaddr = maddr; mddata = mnew;
      end
      mpos++;
    end else if (mpos == 11) begin
      mpos = 12;
    end else begin
      mpos = 0;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic exp_dout;
    exp_dout = (mpos >= 3 && mpos <= 10) ? mcur[mpos-3] : 1'b0;
    chk("R4/R8 ch_val", ch_val, exp_all());
    chk("R3 dout", {31'b0, dout}, {31'b0, exp_dout});
    chk("R7 dout_oe", {31'b0, dout_oe}, {31'b0, cs});
    chk("R5 done", {31'b0, done}, {31'b0, mdone});
    if (mdone) begin
      chk("R5 done_addr", {30'b0, done_addr}, {30'b0, mdaddr});
      chk("R5 done_data", {24'b0, done_data}, {24'b0, mddata});
    end
  endtask

  task automatic cyc(input bit c, input bit d);
    cs = c; di = d;
    @(posedge clk);
    model_step(c, d);
    @(negedge clk);
    compare_all();
  endtask

  // frame with optional abort before data bit 'abort_at' (8 = no abort)
  task automatic frame(input logic [1:0] a, input logic [7:0] d, input bit gap_di,
                       input int abort_at, output logic [7:0] rd);
    rd = 0;
    cyc(1, 1);
    cyc(1, a[0]);
    cyc(1, a[1]);
    rd[0] = dout;
    for (int k = 0; k < 8; k++) begin
      if (k == abort_at) begin
        cyc(0, 0);
        return;
      end
      cyc(1, d[k]);
      if (k < 7) rd[k+1] = dout;
    end
    cyc(1, gap_di);
    cyc(1, gap_di);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int seen;
    #5;
    chk("R9 ch_val in reset without clock", ch_val, nv_data);
    chk("R9 done in reset", {31'b0, done}, 32'd0);
    chk("R7 dout_oe low in reset", {31'b0, dout_oe}, 32'd0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0);

    // R1: idle zeros with cs high
    for (int i = 0; i < 5; i++) cyc(1, 0);
    chk("R1 idle zeros leave outputs", ch_val, nv_data);

    // R2/R3/R4: write channel 2
    frame(2'd2, 8'h9E, 0, 8, rd);
    chk("R3 read-out of channel 2 shadow", {24'b0, rd}, 32'h5A);
    chk("R4 channel 2 new value, others kept", ch_val, 32'hC3_9E_81_17);

    // R2: address 1 lands in slice 1, gap with di=1 ignored (R6)
    frame(2'd1, 8'h11, 1, 8, rd);
    chk("R2 address 1 maps to slice 1", ch_val, 32'hC3_9E_11_17);
    chk("R3 read-out of channel 1 shadow", {24'b0, rd}, 32'h81);

    // R6: start accepted right after two-edge gap
    frame(2'd3, 8'hA5, 0, 8, rd);
    chk("R6 frame after minimum gap", ch_val, 32'hA5_9E_11_17);

    // R3: destructive read returns temporary value
    seen = 0;
    frame(2'd2, 8'h3C, 0, 8, rd);
    chk("R3 read-out returns temporary value", {24'b0, rd}, 32'h9E);
    chk("R4 channel 2 rewritten", ch_val, 32'hA5_3C_11_17);

    // R5: done pulse observed with its fields
    cs = 1; di = 1;
    @(posedge clk); model_step(1, 1);
    @(negedge clk); compare_all();
    cyc(1, 0); cyc(1, 0);
    for (int k = 0; k < 8; k++) cyc(1, k[0]);
    chk("R5 done pulse after last bit", {31'b0, done}, 32'd1);
    chk("R5 done fields", {22'b0, done_addr, done_data}, {22'b0, 2'd0, 8'hAA});
    cyc(1, 0);
    chk("R5 done lasts one cycle", {31'b0, done}, 32'd0);
    cyc(1, 0);

    // R8: drop cs, immediate restore
    cs = 0; #1;
    chk("R8 immediate restore on cs low", ch_val, nv_data);
    chk("R7 dout_oe follows cs", {31'b0, dout_oe}, 32'd0);
    @(negedge clk);
    cyc(0, 1); cyc(0, 0); cyc(0, 1);
    cs = 1; #1;
    chk("R8 temporaries discarded after cs edge", ch_val, nv_data);
    chk("R7 dout_oe high with cs", {31'b0, dout_oe}, 32'd1);
    cyc(1, 0);

    // R10: read-only poll aborted mid frame
    frame(2'd3, 8'hFF, 0, 5, rd);
    chk("R10 poll read-out partial bits", {27'b0, rd[4:0]}, {27'b0, 5'h03});
    chk("R10 aborted frame leaves shadow", ch_val, nv_data);
    cyc(1, 0); cyc(1, 0);
    chk("R10 no temporary after abort", ch_val, nv_data);

    // R4: all four channels, then cs drop (R8)
    for (int a = 0; a < 4; a++) frame(a[1:0], 8'(8'h40 + a), 0, 8, rd);
    chk("R4 all four channels written", ch_val, 32'h43_42_41_40);
    cyc(0, 0);
    chk("R8 all channels back to shadow", ch_val, nv_data);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule